// File: doc/BRIEF.md
# Byte-Packing Data Buffer

This block sits between a 16-bit host data port and a byte-serial bus engine. It holds a small store of bytes. Host writes push bytes into it, and the engine pops them out for sending. The engine also deposits received bytes, and the host pulls them out two at a time. The transmit and receive directions share one store, because a transfer runs in one direction at a time. A separate transmit length and receive length record how many bytes are pending in each direction.

Host writes come in two sizes. A full word shifts the store up by two bytes. A single byte shifts it up by one, and is meant only as the last write of a message. The engine takes transmit bytes oldest first. A byte-order input sets how the two halves of a host word map onto the store, on both the write path and the read path. Each operation raises a one-cycle pulse toward the status logic. The pulses clear or set the transmit-underflow, transmit-ready, receive-overrun, receive-ready and single-byte flags. At the start of a transfer a clear input empties the store. Only one operation is served per clock, chosen by a fixed priority.

Top module: `byte_pack_buffer`

## Requirements
- R1: After reset, and in the cycle after `clear`, the store is zero and `tx_len` and `rx_len` are 0. At that point `tx_avail` is 0 and `rx_room` is 1.
- R2: A word write (`wr_en`=1, `wr_byte`=0) shifts the store left by 16 bits and adds 2 to `tx_len`. With `big_endian`=1, `wr_data[15:8]` lands in store bits 15:8 and `wr_data[7:0]` lands in bits 7:0. With `big_endian`=0, the two bytes land swapped.
- R3: A byte write (`wr_en`=1, `wr_byte`=1) shifts the store left by 8 bits, puts `wr_data[7:0]` in bits 7:0, and adds 1 to `tx_len`.
- R4: A write of either size, made while `tx_len` is 3 or 4, changes nothing and raises no pulse.
- R5: `tx_avail` is 1 whenever `tx_len` is not 0. `tx_byte` shows the store byte at index `tx_len`-1, or 0 when the store is empty. `tx_take` decrements `tx_len`, and has no effect when `tx_len` is 0.
- R6: `rx_push` writes `rx_byte` into the store byte at index `rx_len` and then increments `rx_len`. `rx_room` is 1 while `rx_len` is below 4. A push made when `rx_len` is 4 has no effect.
- R7: `rd_data` shows store bytes 0 and 1. With `big_endian`=1 it is {byte0, byte1}; with 0 it is {byte1, byte0}.
- R8: A read (`rd_en`) adjusts `rx_len` by case. From 1 it goes to 0 and `set_sbd` pulses. From 3 or 4 the store shifts right by 16 and the length drops by 2. From 2 it goes to 0. From 0 it stays 0.
- R9: Every accepted write pulses `clr_xudf`. It also pulses `clr_xrdy` when the resulting `tx_len` exceeds 2.
- R10: Every served read pulses `clr_rovr`. It also pulses `clr_rrdy` when the resulting `rx_len` is 0.
- R11: One request is served per cycle, in this order: `clear`, then a write, then a read, then `tx_take`, then `rx_push`. Any lower request in the same cycle is dropped, even when the winning write is itself rejected under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clear | input | 1 | Empty the store and both lengths |
| big_endian | input | 1 | Byte order of host words |
| wr_en | input | 1 | Host write request |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read request |
| rd_data | output | 16 | Host read data |
| tx_take | input | 1 | Engine consumes one transmit byte |
| tx_byte | output | 8 | Next transmit byte |
| tx_avail | output | 1 | Transmit bytes pending |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | Receive space left |
| tx_len | output | 3 | Pending transmit bytes |
| rx_len | output | 3 | Held receive bytes |
| clr_xudf | output | 1 | Clear transmit-underflow flag |
| clr_xrdy | output | 1 | Clear transmit-ready flag |
| clr_rovr | output | 1 | Clear receive-overrun flag |
| clr_rrdy | output | 1 | Clear receive-ready flag |
| set_sbd | output | 1 | Set single-byte flag |

## Verification
The bench drives both byte orders through both the write path and the read path. A design that mirrored one order onto the other would send or return swapped bytes. The bench also targets the rejected write at lengths 3 and 4. A design that accepted it would overrun the four-byte store and corrupt pending data. Reads are issued at every receive length from 0 to 4; a wrong length update would lose a byte, return a stale byte, or miss the single-byte pulse. Colliding requests check the priority, and a design that served two operations in one cycle would show length changes that do not match either one alone.

// File: rtl/byte_pack_pkg.sv
package byte_pack_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 2;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;

  typedef enum logic [2:0] {
    OP_IDLE, OP_CLEAR, OP_WR_WORD, OP_WR_BYTE, OP_READ, OP_TX, OP_RX
  } op_e;

  // exchange the two bytes of a host word
  function automatic logic [WORD_W-1:0] swap_pair(input logic [WORD_W-1:0] w);
    return {w[BYTE_W-1:0], w[WORD_W-1:BYTE_W]};
  endfunction

  // host word -> low half of store
  function automatic logic [WORD_W-1:0] word_in(input logic [WORD_W-1:0] w, input logic be);
    return be ? w : swap_pair(w);
  endfunction

  // low half of store -> host word
  function automatic logic [WORD_W-1:0] word_out(input logic [WORD_W-1:0] w, input logic be);
    return be ? swap_pair(w) : w;
  endfunction
endpackage

// File: rtl/bpk_op_decode.sv
module bpk_op_decode
  import byte_pack_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic             wr_byte,
  input  logic             rd_en,
  input  logic             tx_take,
  input  logic             rx_push,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  output op_e              op
);
  localparam logic [LEN_W-1:0] WR_LIMIT = LEN_W'(NBYTES - WORD_BYTES);
  localparam logic [LEN_W-1:0] RX_FULL  = LEN_W'(NBYTES);

  // named grant events
  logic wr_fits, tx_has, rx_fits;
  assign wr_fits = (tx_len <= WR_LIMIT);
  assign tx_has  = (tx_len != '0);
  assign rx_fits = (rx_len < RX_FULL);

  always_comb begin
    op = OP_IDLE;
    if (clear)        op = OP_CLEAR;
    else if (wr_en)   op = wr_fits ? (wr_byte ? OP_WR_BYTE : OP_WR_WORD) : OP_IDLE;
    else if (rd_en)   op = OP_READ;
    else if (tx_take) op = tx_has ? OP_TX : OP_IDLE;
    else if (rx_push) op = rx_fits ? OP_RX : OP_IDLE;
  end

  // R11: a read is never served beside a clear or write request
  p_read_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |-> (!clear && !wr_en));
endmodule

// File: rtl/bpk_store.sv
module bpk_store
  import byte_pack_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int LEN_W  = $clog2(NBYTES + 1),
  parameter int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              big_endian,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [LEN_W-1:0]  rx_len,
  output logic [DATA_W-1:0] data_q,
  output logic [BYTE_W-1:0] tx_sel
);
  logic [DATA_W-1:0] data_d;
  logic [LEN_W-1:0]  tx_idx;
  assign tx_idx = tx_len - LEN_W'(1);

  always_comb begin
    data_d = data_q;
    unique case (op)
      OP_CLEAR:   data_d = '0;
      OP_WR_WORD: data_d = (data_q << WORD_W) | DATA_W'(word_in(wr_data, big_endian));
      OP_WR_BYTE: data_d = (data_q << BYTE_W) | DATA_W'(wr_data[BYTE_W-1:0]);
      OP_READ:    if (rx_len > LEN_W'(WORD_BYTES)) data_d = data_q >> WORD_W;
      OP_RX: begin
        for (int i = 0; i < NBYTES; i++)
          if (LEN_W'(i) == rx_len) data_d[i*BYTE_W +: BYTE_W] = rx_byte;
      end
      default: data_d = data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;

  // byte picked for the engine; none matches when empty
  always_comb begin
    tx_sel = '0;
    for (int i = 0; i < NBYTES; i++)
      if (LEN_W'(i) == tx_idx && tx_len != '0) tx_sel = data_q[i*BYTE_W +: BYTE_W];
  end

  // R6: a received byte is visible at its slot on the next cycle
  p_rx_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RX && rx_len == '0) |=> (data_q[BYTE_W-1:0] == $past(rx_byte)));
endmodule

// File: rtl/bpk_tx_count.sv
module bpk_tx_count
  import byte_pack_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  output logic [LEN_W-1:0] tx_q,
  output logic [LEN_W-1:0] tx_next
);
  always_comb begin
    tx_next = tx_q;
    unique case (op)
      OP_CLEAR:   tx_next = '0;
      OP_WR_WORD: tx_next = tx_q + LEN_W'(WORD_BYTES);
      OP_WR_BYTE: tx_next = tx_q + LEN_W'(1);
      OP_TX:      tx_next = tx_q - LEN_W'(1);
      default:    tx_next = tx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_next;

  // R2: pending transmit bytes never exceed the store
  p_tx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q <= LEN_W'(NBYTES));
  // R5: each served take removes exactly one byte
  p_tx_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TX) |=> (tx_q == $past(tx_q) - LEN_W'(1)));
endmodule

// File: rtl/bpk_rx_count.sv
module bpk_rx_count
  import byte_pack_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  output logic [LEN_W-1:0] rx_q,
  output logic [LEN_W-1:0] rx_next
);
  localparam logic [LEN_W-1:0] WB = LEN_W'(WORD_BYTES);

  always_comb begin
    rx_next = rx_q;
    unique case (op)
      OP_CLEAR: rx_next = '0;
      OP_READ:  rx_next = (rx_q >= WB) ? rx_q - WB : '0;
      OP_RX:    rx_next = rx_q + LEN_W'(1);
      default:  rx_next = rx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_next;

  // R6: held receive bytes never exceed the store
  p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_q <= LEN_W'(NBYTES));
  // R8: a read of a lone byte empties the receive side
  p_single_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ && rx_q == LEN_W'(1)) |=> (rx_q == '0));
endmodule

// File: rtl/byte_pack_buffer.sv
module byte_pack_buffer
  import byte_pack_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              big_endian,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  input  logic              tx_take,
  output logic [7:0]        tx_byte,
  output logic              tx_avail,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  output logic              rx_room,
  output logic [LEN_W-1:0]  tx_len,
  output logic [LEN_W-1:0]  rx_len,
  output logic              clr_xudf,
  output logic              clr_xrdy,
  output logic              clr_rovr,
  output logic              clr_rrdy,
  output logic              set_sbd
);
  localparam int DATA_W = NBYTES * BYTE_W;

  op_e               op;
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  tx_next, rx_next;

  bpk_op_decode #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_en(rd_en), .tx_take(tx_take), .rx_push(rx_push),
    .tx_len(tx_len), .rx_len(rx_len), .op(op));

  bpk_store #(.NBYTES(NBYTES), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .big_endian(big_endian),
    .wr_data(wr_data), .rx_byte(rx_byte), .tx_len(tx_len), .rx_len(rx_len),
    .data_q(data_q), .tx_sel(tx_byte));

  bpk_tx_count #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .op(op), .tx_q(tx_len), .tx_next(tx_next));

  bpk_rx_count #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .op(op), .rx_q(rx_len), .rx_next(rx_next));

  // named events for status and assertions
  logic wr_accepted, rd_served;
  assign wr_accepted = (op == OP_WR_WORD) || (op == OP_WR_BYTE);
  assign rd_served   = (op == OP_READ);

  assign rd_data  = word_out(data_q[WORD_W-1:0], big_endian);
  assign tx_avail = (tx_len != '0);
  assign rx_room  = (rx_len < LEN_W'(NBYTES));
  assign clr_xudf = wr_accepted;
  assign clr_xrdy = wr_accepted && (tx_next > LEN_W'(WORD_BYTES));
  assign clr_rovr = rd_served;
  assign clr_rrdy = rd_served && (rx_next == '0);
  assign set_sbd  = rd_served && (rx_len == LEN_W'(1));

  // R1: clear empties both sides
  p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tx_len == '0 && rx_len == '0));
  // R4: an overfull write leaves lengths untouched and raises no pulse
  p_wr_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && wr_en && tx_len > LEN_W'(NBYTES - WORD_BYTES))
      |-> (!clr_xudf ##1 ($stable(tx_len) && $stable(rx_len))));
  // R11: write and read pulses never coexist
  p_one_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_xudf && clr_rovr));
  // R8: single-byte pulse only from a one-byte receive side
  p_sbd_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_sbd |-> (rx_len == LEN_W'(1) && clr_rrdy));
endmodule

// File: tb/test_byte_pack_buffer.sv
module test_byte_pack_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 0, big_endian = 0, wr_en = 0, wr_byte = 0, rd_en = 0;
  logic tx_take = 0, rx_push = 0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] rd_data;
  logic [7:0]  tx_byte;
  logic        tx_avail, rx_room, clr_xudf, clr_xrdy, clr_rovr, clr_rrdy, set_sbd;
  logic [2:0]  tx_len, rx_len;

  int vectors = 0, fails = 0;
  logic [31:0] m_d = '0;
  int m_tx = 0, m_rx = 0;

  always #10 clk = ~clk;

  byte_pack_buffer i_byte_pack_buffer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .big_endian(big_endian),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .tx_take(tx_take), .tx_byte(tx_byte), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_room(rx_room), .tx_len(tx_len),
    .rx_len(rx_len), .clr_xudf(clr_xudf), .clr_xrdy(clr_xrdy), .clr_rovr(clr_rovr),
    .clr_rrdy(clr_rrdy), .set_sbd(set_sbd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] d, input int i);
    return d[i*8 +: 8];
  endfunction

  // expected outputs from the current model state and driven inputs
  task automatic check_now();
    logic wr_ok, rd_go;
    int tx_after, rx_after;
    wr_ok = !clear && wr_en && (m_tx <= 2);
    rd_go = !clear && !wr_en && rd_en;
    tx_after = m_tx + (wr_byte ? 1 : 2);
    rx_after = (m_rx >= 2) ? m_rx - 2 : 0;
    chk("R2 R3 R4 R11 tx_len", 32'(tx_len), 32'(m_tx));
    chk("R6 R8 R11 rx_len", 32'(rx_len), 32'(m_rx));
    chk("R7 rd_data", 32'(rd_data),
        big_endian ? {16'h0, mbyte(m_d,0), mbyte(m_d,1)} : {16'h0, mbyte(m_d,1), mbyte(m_d,0)});
    chk("R5 tx_byte", 32'(tx_byte), (m_tx > 0) ? 32'(mbyte(m_d, m_tx-1)) : 32'h0);
    chk("R5 tx_avail", 32'(tx_avail), 32'(m_tx != 0));
    chk("R6 rx_room", 32'(rx_room), 32'(m_rx < 4));
    chk("R9 R4 clr_xudf", 32'(clr_xudf), 32'(wr_ok));
    chk("R9 clr_xrdy", 32'(clr_xrdy), 32'(wr_ok && tx_after > 2));
    chk("R10 clr_rovr", 32'(clr_rovr), 32'(rd_go));
    chk("R10 clr_rrdy", 32'(clr_rrdy), 32'(rd_go && rx_after == 0));
    chk("R8 set_sbd", 32'(set_sbd), 32'(rd_go && m_rx == 1));
  endtask

  task automatic update_model();
    if (clear) begin
      m_d = '0; m_tx = 0; m_rx = 0;
    end else if (wr_en) begin
      if (m_tx <= 2) begin
        if (wr_byte) begin m_d = {m_d[23:0], wr_data[7:0]}; m_tx += 1; end
        else begin
          m_d = {m_d[15:0], big_endian ? wr_data : {wr_data[7:0], wr_data[15:8]}};
          m_tx += 2;
        end
      end
    end else if (rd_en) begin
      if (m_rx > 2) m_d = {16'h0, m_d[31:16]};
      m_rx = (m_rx >= 2) ? m_rx - 2 : 0;
    end else if (tx_take) begin
      if (m_tx > 0) m_tx -= 1;
    end else if (rx_push) begin
      if (m_rx < 4) begin m_d[m_rx*8 +: 8] = rx_byte; m_rx += 1; end
    end
  endtask

  task automatic cyc(input logic cl, input logic we, input logic wb, input logic [15:0] wd,
                     input logic re, input logic tt, input logic rp, input logic [7:0] rb,
                     input logic be);
    clear = cl; wr_en = we; wr_byte = wb; wr_data = wd; rd_en = re;
    tx_take = tt; rx_push = rp; rx_byte = rb; big_endian = be;
    #2;
    check_now();
    @(posedge clk);
    update_model();
    @(negedge clk);
  endtask

  task automatic wword(input logic [15:0] d, input logic be); cyc(0,1,0,d,0,0,0,8'h0,be); endtask
  task automatic wbyte(input logic [7:0] d);  cyc(0,1,1,{8'h0,d},0,0,0,8'h0,0); endtask
  task automatic take();                       cyc(0,0,0,16'h0,0,1,0,8'h0,0); endtask
  task automatic push(input logic [7:0] b);   cyc(0,0,0,16'h0,0,0,1,b,0); endtask
  task automatic rd(input logic be);           cyc(0,0,0,16'h0,1,0,0,8'h0,be); endtask
  task automatic clr();                        cyc(1,0,0,16'h0,0,0,0,8'h0,0); endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    chk("R1 reset tx_len", 32'(tx_len), 32'h0);
    chk("R1 reset rx_len", 32'(rx_len), 32'h0);
    chk("R1 reset tx_avail", 32'(tx_avail), 32'h0);
    chk("R1 reset rx_room", 32'(rx_room), 32'h1);
    @(negedge clk);

    // R2/R5: word in both orders, drained oldest first
    wword(16'h1234, 0); take(); take(); take();
    wword(16'hA1B2, 1); wword(16'hC3D4, 0); take(); take(); take(); take();
    // R3 then R4: byte after word, rejected writes at 3 and 4
    wword(16'h5566, 1); wbyte(8'h77); wword(16'hDEAD, 1); wbyte(8'h99);
    take(); wword(16'h0102, 0); wword(16'hFFFF, 1); take(); take(); take(); take();
    // R6/R8/R10: receive and read at every length
    rd(0);
    push(8'h11); rd(1);
    push(8'h21); push(8'h22); rd(1);
    push(8'h31); push(8'h32); push(8'h33); rd(0); rd(0);
    push(8'h41); push(8'h42); push(8'h43); push(8'h44); push(8'h45); rd(1); rd(0);
    // R11: collisions
    cyc(0,1,0,16'hBEEF,1,1,1,8'h55,1);
    cyc(0,0,0,16'h0,1,1,1,8'h66,0);
    cyc(0,0,0,16'h0,0,1,1,8'h77,0);
    wword(16'h1111,1); wword(16'h2222,1);
    cyc(0,1,1,16'h0033,1,1,1,8'h88,0);  // rejected write still blocks lower requests
    // R1: clear wins over everything
    cyc(1,1,0,16'h4444,1,1,1,8'h99,1);
    clr();

    for (int n = 0; n < 4000; n++) begin
      logic c, w, b, r, t, p, e;
      c = ($urandom_range(0, 99) < 2);
      w = ($urandom_range(0, 99) < 25);
      b = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 99) < 25);
      t = ($urandom_range(0, 99) < 30);
      p = ($urandom_range(0, 99) < 30);
      e = 1'($urandom_range(0, 1));
      cyc(c, w, b, 16'($urandom), r, t, p, 8'($urandom), e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule